// File: doc/BRIEF.md
# 1-Wire Search Step Sequencer

This block carries out one step of the ROM search on a 1-Wire bus. A start strobe arrives together with a preferred direction bit. The sequencer then asks an external single-bit slot engine for two read slots: the id bit first and its complement second. It decides which branch of the search tree to follow and asks for one write slot that sends the chosen direction back to the bus. It does not generate the slot waveforms itself. It only orders the slots, waits for each one to complete, guards each wait with a timeout and packs the outcome into a 3-bit result word.

Software, or a higher-level search engine, runs the step 64 times to walk a complete ROM code. The result goes out on a valid/ready channel. Once `res_valid` rises, `result` and `res_err` stay frozen until a cycle in which `res_ready` is high. The sequencer stays busy until the result has been taken, so the consumer can stall it for as long as it likes without losing a result. Start, direction, busy and the slot request/done pins are plain control signals.

Top module: `owb_search_step`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. A `start` that arrives while `busy` is high has no effect and produces no extra slot request. After reset, `busy`, `slot_req` and `res_valid` are all low.
- R2: Each step issues its slots in a fixed order: a read (`slot_write`=0) for the id bit, a read for the complement bit, and then, when needed, a write (`slot_write`=1) that carries the direction on `slot_wbit`. Each slot starts with a one-cycle `slot_req` pulse. A slot ends in the first cycle in which `slot_done` is high, and `slot_rbit` is sampled in that cycle.
- R3: When both read bits are 1, the result is 3'b011 and no write slot is issued.
- R4: When both read bits are 0, the direction latched at start is taken. The result is 3'b100 for direction 1 and 3'b000 for direction 0, and that direction is written.
- R5: When exactly one read bit is 1, the direction equals the id bit. The result is 3'b101 when the id bit is 1 and 3'b010 when it is 0, and that bit is written.
- R6: The result packs the id bit in bit 0, the complement bit in bit 1 and the direction taken in bit 2.
- R7: `res_valid` rises in the cycle after the cycle in which `slot_done` ends the write slot. In the no-response case it rises in the cycle after `slot_done` ends the second read.
- R8: A slot whose `slot_done` has not arrived by the TO_CYCLES-th cycle, counting the request cycle as the first, aborts the step. `res_err`=1 and `result`=3'b011 are then presented, and no further slot is requested.
- R9: `dir_req` is sampled only in the cycle in which `start` is accepted. Changing it later in the step does not change the result.
- R10: While `res_valid` is high and `res_ready` is low, `result` and `res_err` hold steady and `busy` stays high. The handshake completes in a cycle with both high, and the following cycle is idle.
- R11: A `slot_done` pulse while the sequencer is idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search step (strobe) |
| dir_req | input | 1 | Preferred direction for a discrepancy |
| busy | output | 1 | Step in progress or result not yet taken |
| slot_req | output | 1 | One-cycle request for a new slot |
| slot_write | output | 1 | Slot kind: 1 write, 0 read; held for the slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | Slot engine reports the slot finished |
| slot_rbit | input | 1 | Bit read, valid with slot_done on reads |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| result | output | 3 | {direction, complement bit, id bit} |
| res_err | output | 1 | Step aborted on slot timeout |

## Verification
The bench builds the block with TO_CYCLES set to 6 instead of the large default. A slot that ends exactly on the last allowed cycle and one that misses it by a single cycle can therefore both be produced within a few cycles. Timeouts can be forced in a read slot and in the write slot. The bench's slot engine model answers with programmable latency, including a completion in the very request cycle, so back-to-back slot requests are also exercised.

// File: rtl/owb_step_pkg.sv
package owb_step_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RD_ID  = 3'd1,
    PH_RD_CMP = 3'd2,
    PH_WRITE  = 3'd3,
    PH_HOLD   = 3'd4
  } phase_t;

  localparam int unsigned RES_BITS = 3;
  localparam logic [RES_BITS-1:0] RES_NO_RESP = 3'b011;
endpackage

// File: rtl/owb_step_timer.sv
module owb_step_timer #(
  parameter int unsigned LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart)        cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/owb_branch_pick.sv
module owb_branch_pick
  import owb_step_pkg::*;
(
  input  logic                id_bit,
  input  logic                cmp_bit,
  input  logic                dir_pref,
  output logic                no_resp,
  output logic                dir_take,
  output logic [RES_BITS-1:0] code
);
  always_comb begin
    no_resp  = id_bit & cmp_bit;
    dir_take = (id_bit == cmp_bit) ? dir_pref : id_bit;
    if (no_resp) code = RES_NO_RESP;
    else         code = {dir_take, cmp_bit, id_bit};
  end
endmodule

// File: rtl/owb_result_slot.sv
module owb_result_slot
  import owb_step_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RES_BITS-1:0] load_code,
  input  logic                load_err,
  input  logic                ready,
  output logic                valid,
  output logic [RES_BITS-1:0] code,
  output logic                err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
      err   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      code  <= load_code;
      err   <= load_err;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/owb_search_step.sv
module owb_search_step
  import owb_step_pkg::*;
#(
  parameter int unsigned TO_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dir_req,
  output logic       busy,
  output logic       slot_req,
  output logic       slot_write,
  output logic       slot_wbit,
  input  logic       slot_done,
  input  logic       slot_rbit,
  output logic       res_valid,
  input  logic       res_ready,
  output logic [2:0] result,
  output logic       res_err
);
  phase_t ph_q, ph_d;
  logic dir_q, id_q;
  logic [RES_BITS-1:0] pend_q;

  logic launch, launch_wr, wbit_d;
  logic in_slot, tmo;
  logic ld, ld_err;
  logic [RES_BITS-1:0] ld_code;
  logic pick_none, pick_dir;
  logic [RES_BITS-1:0] pick_code;

  assign in_slot = (ph_q == PH_RD_ID) || (ph_q == PH_RD_CMP) || (ph_q == PH_WRITE);
  assign busy    = (ph_q != PH_IDLE);

  owb_branch_pick u_pick (
    .id_bit   (id_q),
    .cmp_bit  (slot_rbit),
    .dir_pref (dir_q),
    .no_resp  (pick_none),
    .dir_take (pick_dir),
    .code     (pick_code)
  );

  owb_step_timer #(.LIMIT(TO_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (launch),
    .run     (in_slot),
    .expired (tmo)
  );

  always_comb begin
    ph_d      = ph_q;
    launch    = 1'b0;
    launch_wr = 1'b0;
    wbit_d    = 1'b0;
    ld        = 1'b0;
    ld_err    = 1'b0;
    ld_code   = pend_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_RD_ID;
          launch = 1'b1;
        end
      end
      PH_RD_ID: begin
        if (slot_done) begin
          ph_d   = PH_RD_CMP;
          launch = 1'b1;
        end else if (tmo) begin
          ld = 1'b1; ld_err = 1'b1; ld_code = RES_NO_RESP; ph_d = PH_HOLD;
        end
      end
      PH_RD_CMP: begin
        if (slot_done) begin
          if (pick_none) begin
            ld      = 1'b1;
            ld_code = pick_code;
            ph_d    = PH_HOLD;
          end else begin
            ph_d      = PH_WRITE;
            launch    = 1'b1;
            launch_wr = 1'b1;
            wbit_d    = pick_dir;
          end
        end else if (tmo) begin
          ld = 1'b1; ld_err = 1'b1; ld_code = RES_NO_RESP; ph_d = PH_HOLD;
        end
      end
      PH_WRITE: begin
        if (slot_done) begin
          ld      = 1'b1;
          ld_code = pend_q;
          ph_d    = PH_HOLD;
        end else if (tmo) begin
          ld = 1'b1; ld_err = 1'b1; ld_code = RES_NO_RESP; ph_d = PH_HOLD;
        end
      end
      PH_HOLD: begin
        if (res_ready) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      slot_req   <= 1'b0;
      slot_write <= 1'b0;
      slot_wbit  <= 1'b0;
      dir_q      <= 1'b0;
      id_q       <= 1'b0;
      pend_q     <= '0;
    end else begin
      ph_q     <= ph_d;
      slot_req <= launch;
      if (launch) begin
        slot_write <= launch_wr;
        slot_wbit  <= wbit_d;
      end
      if (ph_q == PH_IDLE && start)      dir_q  <= dir_req;
      if (ph_q == PH_RD_ID && slot_done) id_q   <= slot_rbit;
      if (ph_q == PH_RD_CMP && slot_done) pend_q <= pick_code;
    end
  end

  owb_result_slot u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .load_code (ld_code),
    .load_err  (ld_err),
    .ready     (res_ready),
    .valid     (res_valid),
    .code      (result),
    .err       (res_err)
  );
endmodule

// File: rtl/owb_search_step_chk.sv
module owb_search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       slot_req,
  input logic       slot_write,
  input logic       res_valid,
  input logic       res_ready,
  input logic [2:0] result,
  input logic       res_err
);
  // R1: nothing is requested or presented while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!res_valid && !slot_req));

  // R2: the write slot is the last slot of a step
  a_r2_write_last: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_write) |=> !slot_req);

  // R3: no-response code carries no direction
  a_r3_noresp_dir0: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && result[1:0] == 2'b11) |-> (result[2] == 1'b0));

  // R5: single responder -> direction follows id bit
  a_r5_follow_id: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err && (result[0] != result[1])) |-> (result[2] == result[0]));

  // R8: aborted step reports the no-response code
  a_r8_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (result == 3'b011));

  // R10: result frozen under back-pressure
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && busy && $stable(result) && $stable(res_err)));
endmodule

bind owb_search_step owb_search_step_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .slot_req   (slot_req),
  .slot_write (slot_write),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .result     (result),
  .res_err    (res_err)
);

// File: tb/owb_search_step_tb_top.sv
module owb_search_step_tb_top;
  localparam int TO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_req = 1'b0, slot_done = 1'b0, slot_rbit = 1'b0, res_ready = 1'b1;
  logic busy, slot_req, slot_write, slot_wbit, res_valid, res_err;
  logic [2:0] result;

  always #5 clk = ~clk;

  owb_search_step #(.TO_CYCLES(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_req(dir_req), .busy(busy),
    .slot_req(slot_req), .slot_write(slot_write), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit), .res_valid(res_valid),
    .res_ready(res_ready), .result(result), .res_err(res_err));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- slot engine model ----------------
  bit rbits[$];
  int eng_delay = 0, mute_at = -1, step_reqs = 0, reqs = 0, writes = 0;
  bit eng_spur = 0;
  initial begin
    bit pend = 0, cur_wr = 0, muted = 0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      slot_done = 1'b0;
      if (!rst_n) begin pend = 0; continue; end
      if (slot_req) begin
        pend = 1; cnt = eng_delay; cur_wr = slot_write;
        muted = (step_reqs == mute_at);
        step_reqs++; reqs++;
        if (slot_write) writes++;
      end
      if (pend) begin
        if (!muted) begin
          if (cnt == 0) begin
            slot_done = 1'b1;
            if (!cur_wr) slot_rbit = (rbits.size() > 0) ? rbits.pop_front() : 1'b1;
            pend = 0;
          end else cnt--;
        end
      end else if (eng_spur) begin
        slot_done = 1'b1;
        eng_spur = 0;
      end
    end
  end

  // ---------------- cycle reference model ----------------
  int m_ph = 0, m_wait = 0;
  bit m_dir = 0, m_id = 0, m_req = 0, m_wr = 0, m_wbit = 0, m_valid = 0, m_err = 0;
  bit [2:0] m_res = 0, m_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_req = 0; m_valid = 0; m_wait = 0;
    end else begin
      bit nreq;
      // outputs of the cycle just ending
      chk(busy == (m_ph != 0), "R1 busy per cycle", busy, m_ph != 0);
      chk(slot_req == m_req, "R2 slot_req per cycle", slot_req, m_req);
      if (m_req) chk(slot_write == m_wr, "R2 slot kind", slot_write, m_wr);
      if (m_req && m_wr) chk(slot_wbit == m_wbit, "R4/R5 written bit", slot_wbit, m_wbit);
      chk(res_valid == m_valid, "R7 res_valid timing", res_valid, m_valid);
      if (m_valid) begin
        chk(result == m_res, "R6 result per cycle", result, m_res);
        chk(res_err == m_err, "R8 err per cycle", res_err, m_err);
      end
      nreq = 0;
      case (m_ph)
        0: if (start) begin m_dir = dir_req; m_ph = 1; nreq = 1; m_wr = 0; m_wait = 0; end
        1, 2, 3: begin
          if (slot_done) begin
            if (m_ph == 1) begin m_id = slot_rbit; m_ph = 2; nreq = 1; m_wr = 0; m_wait = 0; end
            else if (m_ph == 2) begin
              if (m_id && slot_rbit) begin
                m_res = 3'b011; m_err = 0; m_valid = 1; m_ph = 4;
              end else begin
                m_wbit = (m_id == slot_rbit) ? m_dir : m_id;
                m_pend = {m_wbit, slot_rbit, m_id};
                m_ph = 3; nreq = 1; m_wr = 1; m_wait = 0;
              end
            end else begin
              m_res = m_pend; m_err = 0; m_valid = 1; m_ph = 4;
            end
          end else if (m_wait == TO - 1) begin
            m_res = 3'b011; m_err = 1; m_valid = 1; m_ph = 4;
          end else m_wait++;
        end
        default: if (res_ready) begin m_valid = 0; m_ph = 0; end
      endcase
      m_req = nreq;
    end
  end

  // expected codes from the requirement text (R3, R4, R5)
  function automatic bit [2:0] exp_code(input bit id, input bit cmp, input bit dir);
    if (id && cmp) return 3'b011;
    if (!id && !cmp) return dir ? 3'b100 : 3'b000;
    return id ? 3'b101 : 3'b010;
  endfunction

  task automatic run_step(input bit id, input bit cmp, input bit dir, input int dly,
                          input int mute, input bit flip,
                          output bit [2:0] got, output bit gerr, output int gw);
    int w0, guard;
    rbits = {id, cmp}; eng_delay = dly; mute_at = mute; step_reqs = 0; w0 = writes;
    @(negedge clk); start = 1'b1; dir_req = dir;
    @(negedge clk); start = 1'b0; if (flip) dir_req = ~dir;
    guard = 0;
    while (!res_valid && guard < 200) begin @(negedge clk); guard++; end
    got = result; gerr = res_err; gw = writes - w0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    bit [2:0] got; bit gerr; int gw, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_valid && !slot_req, "R1 reset state", {busy, res_valid, slot_req}, 0);

    // all read patterns and both preferences (R2 R3 R4 R5 R6)
    for (int k = 0; k < 8; k++) begin
      bit id = k[2], cmp = k[1], dir = k[0];
      run_step(id, cmp, dir, k % 3, -1, 0, got, gerr, gw);
      chk(got == exp_code(id, cmp, dir), "R3/R4/R5 result code", got, exp_code(id, cmp, dir));
      chk(gerr == 0, "R6 no error", gerr, 0);
      chk(gw == ((id && cmp) ? 0 : 1), "R2/R3 write slot count", gw, (id && cmp) ? 0 : 1);
    end

    // R9: preference changed after start
    run_step(0, 0, 1, 2, -1, 1, got, gerr, gw);
    chk(got == 3'b100, "R9 latched direction", got, 3'b100);
    run_step(0, 0, 0, 1, -1, 1, got, gerr, gw);
    chk(got == 3'b000, "R9 latched direction", got, 3'b000);

    // R8: boundary of the timeout window
    run_step(1, 0, 0, TO - 1, -1, 0, got, gerr, gw);
    chk(gerr == 0 && got == 3'b101, "R8 done on last cycle", {gerr, got}, 4'b0101);
    run_step(0, 1, 0, TO, -1, 0, got, gerr, gw);
    chk(gerr == 1 && got == 3'b011, "R8 late done aborts", {gerr, got}, 4'b1011);
    chk(gw == 0, "R8 no slot after abort", gw, 0);
    run_step(0, 0, 1, 0, 2, 0, got, gerr, gw);
    chk(gerr == 1 && got == 3'b011, "R8 write slot timeout", {gerr, got}, 4'b1011);

    // R1: start while busy ignored
    rbits = {1'b1, 1'b0}; eng_delay = 3; mute_at = -1; step_reqs = 0; r0 = reqs;
    @(negedge clk); start = 1'b1; dir_req = 1'b0;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!res_valid) @(negedge clk);
    chk(result == 3'b101, "R1 step unaffected by extra start", result, 3'b101);
    repeat (4) @(negedge clk);
    chk(reqs - r0 == 3, "R1 no extra slots", reqs - r0, 3);

    // R10: back-pressure
    res_ready = 1'b0;
    run_step(0, 1, 1, 1, -1, 0, got, gerr, gw);
    repeat (4) @(negedge clk);
    chk(res_valid && busy && result == 3'b010, "R10 held result", {res_valid, busy, result}, 5'b11010);
    r0 = reqs;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(reqs == r0 && res_valid, "R1 start during hold ignored", reqs - r0, 0);
    res_ready = 1'b1;
    @(negedge clk);
    chk(!res_valid && !busy, "R10 idle after accept", {res_valid, busy}, 0);

    // R11: spurious done while idle
    eng_spur = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !res_valid && !slot_req, "R11 idle done ignored", {busy, res_valid, slot_req}, 0);

    // R7: back-to-back run after spurious done still correct
    run_step(1, 1, 1, 0, -1, 0, got, gerr, gw);
    chk(got == 3'b011 && gw == 0, "R7 no-response result", got, 3'b011);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule